// File: doc/BRIEF.md
# ADC Conversion Trigger Sequencer

This block is the digital control front end of a successive-approximation converter. It holds a small set of configuration fields loaded by a control-register write. From those fields and an asynchronous hardware trigger pin it decides when a conversion begins, whether it repeats, and when it stops. It also produces the converter clock enable with a divide-by-1/2/4/8 divider.

A start pulse and a busy indication form the handshake with the converter back-end. Here the back-end is a fixed-latency stub: it captures the `ana_sample` input when a conversion starts and returns that code after `LAT` converter-clock ticks. The sequencer formats the code as a 10-bit or 8-bit result, holds it in a result register and raises a conversion-complete flag.

The result is a register with a read strobe, not a stream. It is written on every completion whether or not it has been read, so the block applies no back-pressure and needs no valid/ready pair. A reader that falls behind sees the newest result.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The converter clock ticks once every 2^`cfg_div` input clocks, with `cfg_div` values 0..3 giving divide by 1, 2, 4 or 8. In single software mode `done` is first high in the cycle that follows the 2+`LAT`*2^`cfg_div`-th rising edge after the edge that sampled the control write.
- R2: With `cfg_hw_en`=0, a control write whose 5-bit channel field is not 31 (all ones) starts one conversion and raises `busy`.
- R3: A control write with channel 31 starts nothing. It aborts any running conversion, ends continuous operation and drops `busy` on the next edge. It leaves `res_data` unchanged, and while channel 31 is held, trigger edges are ignored.
- R4: A control write during a conversion abandons that conversion. With a valid channel in software mode it starts a new one, so exactly one result arrives, and it is taken from the sample present when the new conversion starts.
- R5: With `cfg_hw_en`=1 the write itself starts nothing. A rising edge on `hw_trig_async`, taken through a two-stage synchroniser, starts a conversion.
- R6: A rising trigger edge that arrives while `busy` is high is ignored.
- R7: With `cfg_cont`=1 a new conversion starts automatically after each result is latched, until the next control write. In hardware mode only the first edge launches the sequence, and later edges change nothing.
- R8: With `cfg_res10`=1 the result is the full 10-bit code. With `cfg_res10`=0 it is code bits 9..2 placed in bits 7..0, and bits 9..8 read zero.
- R9: `done` sets when a result is latched. It stays high until a `res_rd` pulse or a control write clears it. Neither of those changes `res_data`.
- R10: After reset `busy`, `done` and `res_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control-register write strobe |
| cfg_chan | input | 5 | Channel field; 31 means abort/disabled |
| cfg_cont | input | 1 | Continuous operation |
| cfg_hw_en | input | 1 | Start on hardware trigger edges instead of on the write |
| cfg_res10 | input | 1 | 1: 10-bit result, 0: 8-bit result |
| cfg_div | input | 2 | Converter clock divide select |
| res_rd | input | 1 | Result read strobe, clears `done` |
| hw_trig_async | input | 1 | Asynchronous hardware trigger |
| ana_sample | input | 10 | Code the back-end stub captures at conversion start |
| conv_start | output | 1 | One-cycle start pulse to the back-end |
| busy | output | 1 | A conversion or continuous sequence is active |
| done | output | 1 | Conversion-complete flag |
| res_data | output | 10 | Result register |

## Verification
The hardest case to reach is a trigger edge that lands inside a conversion, because the synchroniser delays the edge by three cycles. The stimulus uses the slowest divider so that a second pulse surely falls within the conversion window. It also changes `ana_sample` before that pulse, so a wrongful restart would show up as a different result value. Continuous sequences are aborted one cycle after the last expected result, while the next conversion is still running. The bench then watches for a result that should never appear. Each continuous result carries a distinct code because the sample follows the result count.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned CH_W     = 5;
  localparam int unsigned DIV_W    = 2;
  localparam int unsigned RES_W    = 10;
  localparam int unsigned NARROW_W = 8;
  localparam int unsigned SHIFT_N  = RES_W - NARROW_W;
  localparam logic [CH_W-1:0] CH_OFF = '1;

  typedef enum logic {SEQ_IDLE, SEQ_CONV} seq_state_e;

  typedef struct packed {
    logic [CH_W-1:0]  chan;
    logic             cont;
    logic             hw_en;
    logic             res10;
    logic [DIV_W-1:0] div;
  } seq_cfg_t;

  function automatic logic [RES_W-1:0] fmt_result(input logic [RES_W-1:0] raw,
                                                   input logic wide);
    if (wide) return raw;
    return raw >> SHIFT_N;
  endfunction
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  localparam int unsigned CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;

  always_comb begin
    mask = (CNT_W'(1) << div_sel) - CNT_W'(1);
    tick = (cnt & mask) == mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_async,
  output logic rise
);
  logic [STAGES:0] sr;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sr[0] <= 1'b0;
          else        sr[0] <= trig_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sr[g] <= 1'b0;
          else        sr[g] <= sr[g-1];
        end
      end
    end
  endgenerate

  assign rise = sr[STAGES-1] & ~sr[STAGES];
endmodule

// File: rtl/adc_conv_stub.sv
module adc_conv_stub
  import adc_seq_pkg::*;
#(
  parameter int unsigned LAT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             kill,
  input  logic             tick,
  input  logic [RES_W-1:0] sample_in,
  output logic             busy,
  output logic             res_valid,
  output logic [RES_W-1:0] res_raw
);
  localparam int unsigned LW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [LW-1:0] LAST = LW'(LAT - 1);

  logic [LW-1:0]    cnt;
  logic [RES_W-1:0] cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      res_valid <= 1'b0;
      res_raw   <= '0;
      cnt       <= '0;
      cap       <= '0;
    end else begin
      res_valid <= 1'b0;
      if (kill) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
        cap  <= sample_in;
      end else if (busy && tick) begin
        if (cnt == LAST) begin
          busy      <= 1'b0;
          res_valid <= 1'b1;
          res_raw   <= cap;
        end else begin
          cnt <= cnt + LW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  seq_cfg_t         cfg_in,
  input  logic             res_rd,
  input  logic             trig_rise,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_raw,
  output seq_cfg_t         cfg_q,
  output logic             conv_start,
  output logic             kill,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] res_data
);
  seq_state_e state;
  logic       chan_ok_in;
  logic       chan_ok_q;
  logic       hw_go;

  assign chan_ok_in = cfg_in.chan != CH_OFF;
  assign chan_ok_q  = cfg_q.chan != CH_OFF;
  assign hw_go      = trig_rise && cfg_q.hw_en && chan_ok_q && (state == SEQ_IDLE);
  assign kill       = cfg_wr;
  assign busy       = state == SEQ_CONV;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SEQ_IDLE;
      cfg_q      <= '{chan: CH_OFF, default: '0};
      conv_start <= 1'b0;
      done       <= 1'b0;
      res_data   <= '0;
    end else begin
      conv_start <= 1'b0;
      if (cfg_wr) begin
        cfg_q <= cfg_in;
        done  <= 1'b0;
        if (chan_ok_in && !cfg_in.hw_en) begin
          state      <= SEQ_CONV;
          conv_start <= 1'b1;
        end else begin
          state <= SEQ_IDLE;
        end
      end else begin
        if (res_rd) done <= 1'b0;
        if (hw_go) begin
          state      <= SEQ_CONV;
          conv_start <= 1'b1;
        end
        if (res_valid && state == SEQ_CONV) begin
          res_data <= fmt_result(res_raw, cfg_q.res10);
          done     <= 1'b1;
          if (cfg_q.cont) conv_start <= 1'b1;
          else            state      <= SEQ_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned LAT         = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CH_W-1:0]  cfg_chan,
  input  logic             cfg_cont,
  input  logic             cfg_hw_en,
  input  logic             cfg_res10,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             res_rd,
  input  logic             hw_trig_async,
  input  logic [RES_W-1:0] ana_sample,
  output logic             conv_start,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] res_data
);
  seq_cfg_t         cfg_in;
  seq_cfg_t         cfg_q;
  logic             trig_rise;
  logic             tick;
  logic             kill;
  logic             stub_busy;
  logic             res_valid;
  logic [RES_W-1:0] res_raw;

  assign cfg_in = '{chan: cfg_chan, cont: cfg_cont, hw_en: cfg_hw_en,
                    res10: cfg_res10, div: cfg_div};

  adc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .trig_async(hw_trig_async), .rise(trig_rise)
  );

  adc_clk_div u_div (
    .clk(clk), .rst_n(rst_n), .clr(conv_start), .div_sel(cfg_q.div), .tick(tick)
  );

  adc_conv_stub #(.LAT(LAT)) u_stub (
    .clk(clk), .rst_n(rst_n), .start(conv_start), .kill(kill), .tick(tick),
    .sample_in(ana_sample), .busy(stub_busy), .res_valid(res_valid), .res_raw(res_raw)
  );

  adc_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_in(cfg_in), .res_rd(res_rd),
    .trig_rise(trig_rise), .res_valid(res_valid), .res_raw(res_raw), .cfg_q(cfg_q),
    .conv_start(conv_start), .kill(kill), .busy(busy), .done(done), .res_data(res_data)
  );
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk
  import adc_seq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_wr,
  input logic [CH_W-1:0] cfg_chan,
  input logic            res_rd,
  input logic            conv_start,
  input logic            busy,
  input logic            done,
  input logic            res_valid,
  input logic            stub_busy
);
  // R9
  done_from_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(res_valid));

  // R9
  wr_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !done);

  // R9
  read_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_rd && !cfg_wr && !res_valid) |=> !done);

  // R3
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_chan == CH_OFF) |=> !busy);

  // R6
  no_start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !stub_busy);

  // R2
  backend_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stub_busy) |-> $past(conv_start));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_chan(cfg_chan), .res_rd(res_rd),
  .conv_start(conv_start), .busy(busy), .done(done), .res_valid(res_valid),
  .stub_busy(stub_busy)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  localparam int LAT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [4:0] cfg_chan = 5'd31;
  logic       cfg_cont = 1'b0, cfg_hw_en = 1'b0, cfg_res10 = 1'b1;
  logic [1:0] cfg_div = 2'd0;
  logic       main_rd = 1'b0, mon_rd = 1'b0;
  logic       res_rd;
  logic       hw_trig = 1'b0;
  logic [9:0] ana_sample;
  logic [9:0] man_sample = '0;
  logic [9:0] seq_base = '0;
  logic       seq_samp = 1'b0;
  logic       conv_start, busy, done;
  logic [9:0] res_data;

  int checks = 0;
  int errors = 0;
  int mon_count = 0;
  bit autord = 1'b1;
  logic [9:0] exp_q[$];

  assign res_rd = main_rd | mon_rd;
  assign ana_sample = seq_samp ? seq_base + 10'(mon_count) : man_sample;

  always #10 clk = ~clk;

  adc_seq_ctrl #(.LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_chan(cfg_chan), .cfg_cont(cfg_cont),
    .cfg_hw_en(cfg_hw_en), .cfg_res10(cfg_res10), .cfg_div(cfg_div), .res_rd(res_rd),
    .hw_trig_async(hw_trig), .ana_sample(ana_sample), .conv_start(conv_start),
    .busy(busy), .done(done), .res_data(res_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [4:0] ch, input logic cont, input logic hw,
                           input logic r10, input logic [1:0] dv);
    @(negedge clk);
    cfg_chan = ch; cfg_cont = cont; cfg_hw_en = hw; cfg_res10 = r10; cfg_div = dv;
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); hw_trig = 1'b1;
    repeat (3) @(negedge clk);
    hw_trig = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [9:0] expect_of(input logic [9:0] s, input logic r10);
    return r10 ? s : {2'b00, s[9:2]};
  endfunction

  task automatic wait_results(input int n);
    int target;
    target = mon_count + n;
    while (mon_count < target) @(negedge clk);
  endtask

  task automatic measure(input int exp_lat, input string req);
    int k;
    k = 0;
    forever begin
      @(posedge clk); k++;
      @(negedge clk);
      if (done || k > 500) break;
    end
    chk(k == exp_lat, req, k, exp_lat);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    logic done_prev;
    done_prev = 1'b0;
    forever begin
      @(negedge clk);
      mon_rd = 1'b0;
      if (rst_n && done && !done_prev) begin
        mon_count++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3/R4/R6 unexpected result", res_data, 0);
        end else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          chk(res_data == e, "R8 result value", res_data, e);
        end
        if (autord) mon_rd = 1'b1;
      end
      done_prev = done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R10 reset state
    chk(busy == 1'b0, "R10 busy", busy, 0);
    chk(done == 1'b0, "R10 done", done, 0);
    chk(res_data == 10'd0, "R10 res_data", res_data, 0);

    // R1 R2 R8: software single conversions at several dividers
    man_sample = 10'h2A5; exp_q.push_back(expect_of(10'h2A5, 1'b1));
    write_cfg(5'd3, 1'b0, 1'b0, 1'b1, 2'd2);
    measure(2 + LAT * 4, "R1 latency div4");
    idle(3);
    man_sample = 10'h3C7; exp_q.push_back(expect_of(10'h3C7, 1'b0));
    write_cfg(5'd0, 1'b0, 1'b0, 1'b0, 2'd0);
    measure(2 + LAT * 1, "R1 latency div1");
    idle(3);
    man_sample = 10'h155; exp_q.push_back(expect_of(10'h155, 1'b1));
    write_cfg(5'd7, 1'b0, 1'b0, 1'b1, 2'd3);
    measure(2 + LAT * 8, "R1 latency div8");
    idle(3);
    chk(busy == 1'b0, "R2 single returns idle", busy, 0);

    // R3: all-ones write from idle starts nothing
    c0 = mon_count;
    write_cfg(5'd31, 1'b0, 1'b0, 1'b1, 2'd0);
    idle(40);
    chk(busy == 1'b0, "R3 no start on chan 31", busy, 0);
    chk(mon_count == c0, "R3 no result", mon_count, c0);

    // R3: abort during conversion keeps old result
    man_sample = 10'h0AA;
    write_cfg(5'd2, 1'b0, 1'b0, 1'b1, 2'd3);
    idle(10);
    chk(busy == 1'b1, "R2 busy during conversion", busy, 1);
    write_cfg(5'd31, 1'b0, 1'b0, 1'b1, 2'd3);
    chk(busy == 1'b0, "R3 abort drops busy", busy, 0);
    idle(60);
    chk(res_data == 10'h155, "R3 result untouched", res_data, 10'h155);
    chk(mon_count == c0, "R3 aborted no result", mon_count, c0);

    // R4: rewrite during conversion restarts with new sample
    man_sample = 10'h111;
    write_cfg(5'd3, 1'b0, 1'b0, 1'b1, 2'd2);
    idle(8);
    man_sample = 10'h222; exp_q.push_back(10'h222);
    write_cfg(5'd4, 1'b0, 1'b0, 1'b1, 2'd2);
    wait_results(1);
    c0 = mon_count;
    idle(40);
    chk(mon_count == c0, "R4 single result after restart", mon_count, c0);

    // R5: hardware trigger, write alone does not start
    man_sample = 10'h300;
    write_cfg(5'd2, 1'b0, 1'b1, 1'b1, 2'd1);
    idle(30);
    chk(busy == 1'b0, "R5 write does not start in hw mode", busy, 0);
    exp_q.push_back(10'h300);
    pulse_trig();
    wait_results(1);
    idle(5);

    // R6: edge while busy ignored
    write_cfg(5'd2, 1'b0, 1'b1, 1'b1, 2'd3);
    man_sample = 10'h0F0; exp_q.push_back(10'h0F0);
    pulse_trig();
    idle(4);
    chk(busy == 1'b1, "R6 busy before second edge", busy, 1);
    man_sample = 10'h0AB;
    pulse_trig();
    wait_results(1);
    c0 = mon_count;
    idle(80);
    chk(mon_count == c0, "R6 second edge ignored", mon_count, c0);

    // R7: software continuous with changing samples
    seq_base = 10'h101 - 10'(mon_count);
    seq_samp = 1'b1;
    for (int i = 0; i < 4; i++) exp_q.push_back(10'h101 + 10'(i));
    write_cfg(5'd1, 1'b1, 1'b0, 1'b1, 2'd0);
    wait_results(4);
    write_cfg(5'd31, 1'b0, 1'b0, 1'b1, 2'd0);
    seq_samp = 1'b0;
    c0 = mon_count;
    idle(40);
    chk(busy == 1'b0, "R7 continuous stopped by abort", busy, 0);
    chk(mon_count == c0, "R7 no result after abort", mon_count, c0);

    // R7: hardware continuous, only first edge launches
    man_sample = 10'h2C8;
    write_cfg(5'd1, 1'b1, 1'b1, 1'b0, 2'd2);
    idle(20);
    chk(busy == 1'b0, "R7 hw continuous waits for edge", busy, 0);
    for (int i = 0; i < 3; i++) exp_q.push_back(expect_of(10'h2C8, 1'b0));
    pulse_trig();
    wait_results(2);
    pulse_trig();
    wait_results(1);
    write_cfg(5'd31, 1'b0, 1'b0, 1'b1, 2'd0);
    c0 = mon_count;
    idle(50);
    chk(mon_count == c0, "R7 hw sequence ended by abort", mon_count, c0);
    chk(busy == 1'b0, "R7 idle after abort", busy, 0);

    // R3: trigger ignored while channel 31 with hw enabled
    write_cfg(5'd31, 1'b0, 1'b1, 1'b1, 2'd0);
    pulse_trig();
    idle(20);
    chk(busy == 1'b0, "R3 edge ignored on chan 31", busy, 0);

    // R9: flag hold, read clear, write clear
    autord = 1'b0;
    man_sample = 10'h3FF; exp_q.push_back(10'h3FF);
    write_cfg(5'd5, 1'b0, 1'b0, 1'b1, 2'd0);
    wait_results(1);
    idle(5);
    chk(done == 1'b1, "R9 done holds", done, 1);
    main_rd = 1'b1;
    @(negedge clk);
    main_rd = 1'b0;
    chk(done == 1'b0, "R9 read clears done", done, 0);
    chk(res_data == 10'h3FF, "R9 read keeps data", res_data, 10'h3FF);
    man_sample = 10'h1C4; exp_q.push_back(10'h071);
    write_cfg(5'd6, 1'b0, 1'b0, 1'b0, 2'd0);
    wait_results(1);
    idle(2);
    write_cfg(5'd31, 1'b0, 1'b0, 1'b0, 2'd0);
    chk(done == 1'b0, "R9 write clears done", done, 0);
    chk(res_data == 10'h071, "R9 write keeps data", res_data, 10'h071);
    chk(exp_q.size() == 0, "R8 all expected results seen", exp_q.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule